// File: doc/BRIEF.md
# Four-Channel DMA Transfer Controller

This block moves data on behalf of up to four peripherals without processor involvement. A peripheral raises its request line. The controller asks for the system bus with a hold request and waits for the acknowledge. It then drives one channel's acknowledge and current address for each transfer cycle. On every beat the channel's address goes up by one and its word count goes down by one. When the count runs out, the controller pulses a terminal-count strobe, records the event in a status register and gives the bus back.

Software programs the block through a small byte-wide register port. Each channel has a 16-bit start address and a 16-bit word count. Each of these is loaded with two byte writes, and an internal low/high pointer picks the half. A mode register enables channels and selects per-channel auto-load. With auto-load set, a channel restores its programmed address and count after terminal count, so the same block can repeat. A control bit picks fixed or rotating arbitration between channels that request together.

Top module: `dma4_ctrl`

## Requirements
- R1: After reset, hold_req, dack and tc_out are low. The status word (register select 8, read strobe high) reads 0. The byte pointer points at the low byte. Auto-load is off, no channel is enabled and the priority mode is fixed.
- R2: Register selects 0 to 7 address the channel registers. Channel n's address is at select 2n and its count is at select 2n+1. Each 16-bit value takes two byte writes, low byte first. One shared pointer toggles on every channel-register write and returns to the low byte on reset.
- R3: A channel takes part in arbitration only when three things hold: its dreq is high, its enable bit (mode register, select 8 write, bits 3:0) is set, and its count is nonzero. A request from any other channel never raises hold_req or its dack.
- R4: The block raises hold_req when an eligible request appears. No dack is driven until hold_ack is high. At most one dack bit is high at any time.
- R5: During each beat, addr_out shows the channel's current address. After the beat, the address has risen by one (wrapping at 16 bits) and the count has fallen by one. A channel programmed with count N performs exactly N beats, starting at its programmed address.
- R6: tc_out is high on the last beat of a block, the beat on which the count goes from 1 to 0. hold_req is low in the cycle after that beat.
- R7: With the rotate bit (select 9 write, bit 0) clear, the lowest-numbered eligible channel wins arbitration.
- R8: With the rotate bit set, the search starts at the channel after the one that most recently reached terminal count, so that channel has the lowest priority.
- R9: Status bits 3:0 hold one sticky terminal-count flag per channel, set by that channel's tc_out. A status read clears them on the following clock edge. A flag that is set in the same cycle as a read survives the read.
- R10: When a channel's auto-load bit (mode bits 7:4) is set, its terminal count restores its current address and count from the programmed values. A new request then repeats the same block.
- R11: Status bit 4 is an update flag. It is set by any high-byte write to a channel register. A status read leaves it unchanged. It is cleared by reset, by a mode write with any auto-load bit set, and by an auto-load restore.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Status read strobe |
| cpu_sel | input | 4 | Register select |
| cpu_wdata | input | 8 | Write data byte |
| cpu_rdata | output | 8 | Status word while reading select 8, else 0 |
| dreq | input | 4 | Per-channel transfer requests |
| hold_req | output | 1 | Bus ownership request |
| hold_ack | input | 1 | Bus ownership granted |
| dack | output | 4 | One-hot active channel acknowledge |
| addr_out | output | 16 | Current transfer address |
| tc_out | output | 1 | Terminal-count strobe on the final beat |

## Verification
The bench aims at four corner cases.

- **Address wrap and byte order.** Blocks start at addresses that cross a low-byte carry and wrap at 0xFFFF. A design that swapped the byte halves, or carried incorrectly, would show a wrong first or last address.
- **Arbitration.** Simultaneous requests are run in fixed and rotating modes. An arbiter that ignored the last-serviced channel would hand ch0 the bus where ch2 is due.
- **Gating.** A disabled channel is held requesting, and an enabled one is held waiting without acknowledge. A leaky enable or a missing handshake would show acknowledges on dack.
- **Status side effects.** The status word is read twice to confirm that the terminal-count flags clear while the update flag stays. An auto-load block is then repeated. A design that failed to restore the channel would run a short or shifted second block.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_XFER = 2'd2
   } dma_state_e;
endpackage

// File: rtl/dma4_chan.sv
// One channel: programmed (base) values plus working address and count.
module dma4_chan #(
   parameter int AW = 16,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          wr_is_cnt,
   input  logic          wr_hi,
   input  logic [DW-1:0] wdata,
   input  logic          step,
   input  logic          reload,
   output logic [AW-1:0] cur_addr,
   output logic [AW-1:0] cur_cnt
);
   logic [AW-1:0] base_addr, base_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_addr <= '0;
         base_cnt  <= '0;
         cur_addr  <= '0;
         cur_cnt   <= '0;
      end else if (wr_en) begin
         if (wr_is_cnt) begin
            if (wr_hi) begin
               base_cnt[AW-1:DW] <= wdata;
               cur_cnt[AW-1:DW]  <= wdata;
            end else begin
               base_cnt[DW-1:0] <= wdata;
               cur_cnt[DW-1:0]  <= wdata;
            end
         end else begin
            if (wr_hi) begin
               base_addr[AW-1:DW] <= wdata;
               cur_addr[AW-1:DW]  <= wdata;
            end else begin
               base_addr[DW-1:0] <= wdata;
               cur_addr[DW-1:0]  <= wdata;
            end
         end
      end else if (reload) begin
         cur_addr <= base_addr;
         cur_cnt  <= base_cnt;
      end else if (step) begin
         cur_addr <= cur_addr + AW'(1);
         cur_cnt  <= cur_cnt - AW'(1);
      end
   end
endmodule

// File: rtl/dma4_arb.sv
// Picks one requesting channel; the rotating variant can be compiled out.
module dma4_arb #(
   parameter int NUM_CH     = 4,
   parameter bit HAS_ROTATE = 1'b1,
   localparam int IDX_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic [NUM_CH-1:0] req,
   input  logic              rotate,
   input  logic [IDX_W-1:0]  last,
   output logic [IDX_W-1:0]  gnt_idx,
   output logic              gnt_any
);
   assign gnt_any = |req;

   if (HAS_ROTATE) begin : g_rot
      always_comb begin
         int  idx;
         logic found;
         gnt_idx = '0;
         found   = 1'b0;
         for (int k = 0; k < NUM_CH; k++) begin
            idx = rotate ? ((int'(last) + 1 + k) % NUM_CH) : k;
            if (!found && req[idx]) begin
               found   = 1'b1;
               gnt_idx = idx[IDX_W-1:0];
            end
         end
      end
   end else begin : g_fixed
      always_comb begin
         gnt_idx = '0;
         for (int k = NUM_CH - 1; k >= 0; k--) begin
            if (req[k]) gnt_idx = k[IDX_W-1:0];
         end
      end
   end
endmodule

// File: rtl/dma4_ctrl.sv
module dma4_ctrl #(
   parameter int NUM_CH     = 4,
   parameter int AW         = 16,
   parameter int DW         = 8,
   parameter int SEL_W      = 4,
   parameter bit HAS_ROTATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_wr,
   input  logic              cpu_rd,
   input  logic [SEL_W-1:0]  cpu_sel,
   input  logic [DW-1:0]     cpu_wdata,
   output logic [DW-1:0]     cpu_rdata,
   input  logic [NUM_CH-1:0] dreq,
   output logic              hold_req,
   input  logic              hold_ack,
   output logic [NUM_CH-1:0] dack,
   output logic [AW-1:0]     addr_out,
   output logic              tc_out
);
   import dma4_pkg::*;

   localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
   localparam logic [SEL_W-1:0] SEL_MODE = SEL_W'(2 * NUM_CH);
   localparam logic [SEL_W-1:0] SEL_CTRL = SEL_W'(2 * NUM_CH + 1);

   initial begin
      assert (AW == 2 * DW) else $error("address width must be two data bytes");
      assert (DW >= 2 * NUM_CH) else $error("mode byte too narrow");
      assert (DW >= NUM_CH + 1) else $error("status byte too narrow");
      assert ((1 << SEL_W) >= 2 * NUM_CH + 2) else $error("select too narrow");
   end

   dma_state_e        state;
   logic [IDX_W-1:0]  act_ch, last_ch, gnt_idx;
   logic              gnt_any;
   logic [NUM_CH-1:0] en_bits, al_bits, eligible, tc_stat;
   logic              rotate, hi_ptr, upd_flag;
   logic [AW-1:0]     ch_addr [NUM_CH];
   logic [AW-1:0]     ch_cnt  [NUM_CH];
   logic [NUM_CH-1:0] step_vec, reload_vec, wr_vec;
   logic              chan_wr, mode_wr, ctrl_wr, stat_rd, xfer_go, tc_now;
   logic [DW-1:0]     status_word;

   assign chan_wr = cpu_wr && (cpu_sel < SEL_MODE);
   assign mode_wr = cpu_wr && (cpu_sel == SEL_MODE);
   assign ctrl_wr = cpu_wr && (cpu_sel == SEL_CTRL);
   assign stat_rd = cpu_rd && (cpu_sel == SEL_MODE);

   assign xfer_go  = (state == ST_XFER) && hold_ack;
   assign tc_now   = (ch_cnt[act_ch] <= AW'(1));
   assign hold_req = (state != ST_IDLE);
   assign addr_out = ch_addr[act_ch];
   assign tc_out   = xfer_go && tc_now;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      assign wr_vec[i]     = chan_wr && (cpu_sel[IDX_W:1] == IDX_W'(i));
      assign step_vec[i]   = xfer_go && (act_ch == IDX_W'(i));
      assign reload_vec[i] = step_vec[i] && tc_now && al_bits[i];
      assign eligible[i]   = dreq[i] && en_bits[i] && (ch_cnt[i] != '0);
      assign dack[i]       = step_vec[i];

      dma4_chan #(.AW(AW), .DW(DW)) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en     (wr_vec[i]),
         .wr_is_cnt (cpu_sel[0]),
         .wr_hi     (hi_ptr),
         .wdata     (cpu_wdata),
         .step      (step_vec[i]),
         .reload    (reload_vec[i]),
         .cur_addr  (ch_addr[i]),
         .cur_cnt   (ch_cnt[i])
      );
   end

   dma4_arb #(.NUM_CH(NUM_CH), .HAS_ROTATE(HAS_ROTATE)) u_arb (
      .req     (eligible),
      .rotate  (rotate),
      .last    (last_ch),
      .gnt_idx (gnt_idx),
      .gnt_any (gnt_any)
   );

   // CPU-side registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_ptr   <= 1'b0;
         en_bits  <= '0;
         al_bits  <= '0;
         rotate   <= 1'b0;
         upd_flag <= 1'b0;
         tc_stat  <= '0;
      end else begin
         if (chan_wr) hi_ptr <= ~hi_ptr;
         if (mode_wr) begin
            en_bits <= cpu_wdata[NUM_CH-1:0];
            al_bits <= cpu_wdata[2*NUM_CH-1:NUM_CH];
         end
         if (ctrl_wr) rotate <= cpu_wdata[0];
         if ((mode_wr && (cpu_wdata[2*NUM_CH-1:NUM_CH] != '0)) || (|reload_vec))
            upd_flag <= 1'b0;
         else if (chan_wr && hi_ptr)
            upd_flag <= 1'b1;
         tc_stat <= (stat_rd ? '0 : tc_stat) | (tc_out ? step_vec : '0);
      end
   end

   always_comb begin
      status_word             = '0;
      status_word[NUM_CH-1:0] = tc_stat;
      status_word[NUM_CH]     = upd_flag;
   end
   assign cpu_rdata = stat_rd ? status_word : '0;

   // Bus ownership sequencing
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         act_ch  <= '0;
         last_ch <= IDX_W'(NUM_CH - 1);
      end else begin
         unique case (state)
            ST_IDLE: if (gnt_any) state <= ST_REQ;
            ST_REQ: if (hold_ack) begin
               if (gnt_any) begin
                  act_ch <= gnt_idx;
                  state  <= ST_XFER;
               end else begin
                  state <= ST_IDLE;
               end
            end
            ST_XFER: if (xfer_go && tc_now) begin
               last_ch <= act_ch;
               state   <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dma4_ctrl_chk.sv
module dma4_ctrl_chk #(
   parameter int NUM_CH = 4,
   parameter int AW     = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hold_req,
   input logic              hold_ack,
   input logic [NUM_CH-1:0] dack,
   input logic [AW-1:0]     addr_out,
   input logic              tc_out,
   input logic [NUM_CH-1:0] tc_stat
);
   assert_dack_needs_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (dack != '0) |-> (hold_req && hold_ack));

   assert_dack_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dack));

   assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((dack != '0) && !tc_out) ##1 (dack != '0) |-> (addr_out == $past(addr_out) + AW'(1)));

   assert_tc_on_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tc_out |-> (dack != '0));

   assert_tc_drops_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tc_out |=> !hold_req);

   assert_tc_sets_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
      tc_out |=> ((tc_stat & $past(dack)) == $past(dack)));
endmodule

bind dma4_ctrl dma4_ctrl_chk #(.NUM_CH(NUM_CH), .AW(AW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .hold_req (hold_req),
   .hold_ack (hold_ack),
   .dack     (dack),
   .addr_out (addr_out),
   .tc_out   (tc_out),
   .tc_stat  (tc_stat)
);

// File: tb/dma4_ctrl_bench.sv
`timescale 1ns/1ps
module dma4_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
   logic [3:0]  cpu_sel = '0;
   logic [7:0]  cpu_wdata = '0;
   logic [7:0]  cpu_rdata;
   logic [3:0]  dreq = '0;
   logic        hold_req, hold_ack = 1'b1;
   logic [3:0]  dack;
   logic [15:0] addr_out;
   logic        tc_out;

   int n_chk = 0, n_bad = 0;

   always #2 clk = ~clk;

   dma4_ctrl u_dma4_ctrl (
      .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
      .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .dreq(dreq), .hold_req(hold_req), .hold_ack(hold_ack),
      .dack(dack), .addr_out(addr_out), .tc_out(tc_out)
   );

   // {channel, start address, count}
   localparam logic [33:0] VEC [4] = '{
      {2'd0, 16'h1234, 16'd3},
      {2'd1, 16'hABFE, 16'd4},
      {2'd2, 16'h00FF, 16'd1},
      {2'd3, 16'hFFFE, 16'd3}
   };

   task automatic check(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] s, input logic [7:0] d);
      @(negedge clk);
      cpu_sel = s; cpu_wdata = d; cpu_wr = 1'b1;
      @(negedge clk);
      cpu_wr = 1'b0;
   endtask

   task automatic program_ch(input int ch, input logic [15:0] a, input logic [15:0] c);
      wr(4'(2*ch), a[7:0]);   wr(4'(2*ch), a[15:8]);
      wr(4'(2*ch+1), c[7:0]); wr(4'(2*ch+1), c[15:8]);
   endtask

   task automatic rd_stat(output logic [7:0] v);
      @(negedge clk);
      cpu_sel = 4'd8; cpu_rd = 1'b1;
      #1 v = cpu_rdata;
      @(negedge clk);
      cpu_rd = 1'b0;
   endtask

   // Follow one block until terminal count; drop that channel's request.
   task automatic run_blk(output int ch, output int first, output int last, output int beats);
      ch = -1; first = 0; last = 0; beats = 0;
      for (int t = 0; t < 200; t++) begin
         @(negedge clk);
         if (dack != '0) begin
            if (beats == 0) begin
               first = addr_out;
               for (int i = 0; i < 4; i++) if (dack[i]) ch = i;
            end
            beats++;
            last = addr_out;
            if (tc_out) begin
               dreq[ch] = 1'b0;
               return;
            end
         end
      end
   endtask

   initial begin
      #(4 * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] st;
      int ch, first, last, beats, seen;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      @(negedge clk);
      check("R1 hold_req", hold_req, 0);
      check("R1 dack", dack, 0);
      check("R1 tc_out", tc_out, 0);
      rd_stat(st);
      check("R1 status", st, 0);

      // Table of blocks: R2 byte order, R5 stepping, R6 tc, R9 status
      for (int v = 0; v < 4; v++) begin
         int vc = int'(VEC[v][33:32]);
         logic [15:0] va = VEC[v][31:16];
         logic [15:0] vn = VEC[v][15:0];
         program_ch(vc, va, vn);
         wr(4'd8, 8'(1 << vc));
         @(negedge clk); dreq[vc] = 1'b1;
         run_blk(ch, first, last, beats);
         check("R5 channel", ch, vc);
         check("R2 first address", first, va);
         check("R5 beat count", beats, vn);
         check("R6 last address", last, 16'(va + vn - 16'd1));
         @(negedge clk);
         check("R6 hold dropped", hold_req, 0);
         rd_stat(st);
         check("R9 tc status set", st, 8'h10 | 8'(1 << vc));
         rd_stat(st);
         check("R9 tc cleared / R11 update kept", st, 8'h10);
      end

      // R3 disabled channel ignored
      wr(4'd8, 8'h00);
      program_ch(0, 16'h0500, 16'd2);
      @(negedge clk); dreq[0] = 1'b1;
      seen = 0;
      for (int t = 0; t < 10; t++) begin
         @(negedge clk);
         if (hold_req || dack != '0) seen++;
      end
      check("R3 disabled ignored", seen, 0);

      // R4 no dack before hold_ack
      hold_ack = 1'b0;
      wr(4'd8, 8'h01);
      seen = 0;
      for (int t = 0; t < 8; t++) begin
         @(negedge clk);
         if (dack != '0) seen++;
      end
      check("R4 no dack without ack", seen, 0);
      check("R4 hold_req raised", hold_req, 1);
      hold_ack = 1'b1;
      run_blk(ch, first, last, beats);
      check("R4 block after ack", beats, 2);
      rd_stat(st);

      // R7 fixed priority
      wr(4'd9, 8'h00);
      program_ch(1, 16'h0100, 16'd2);
      program_ch(2, 16'h0200, 16'd2);
      wr(4'd8, 8'h06);
      @(negedge clk); dreq = 4'b0110;
      run_blk(ch, first, last, beats);
      check("R7 fixed first", ch, 1);
      run_blk(ch, first, last, beats);
      check("R7 fixed second", ch, 2);

      // R8 rotating priority
      wr(4'd9, 8'h01);
      program_ch(0, 16'h0000, 16'd2);
      program_ch(1, 16'h0100, 16'd2);
      program_ch(2, 16'h0200, 16'd2);
      wr(4'd8, 8'h07);
      @(negedge clk); dreq = 4'b0010;
      run_blk(ch, first, last, beats);
      check("R8 lone channel", ch, 1);
      program_ch(1, 16'h0100, 16'd2);
      @(negedge clk); dreq = 4'b0111;
      run_blk(ch, first, last, beats);
      check("R8 rotate first", ch, 2);
      run_blk(ch, first, last, beats);
      check("R8 rotate second", ch, 0);
      run_blk(ch, first, last, beats);
      check("R8 rotate third", ch, 1);
      wr(4'd9, 8'h00);
      rd_stat(st);

      // R11 mode write with auto-load clears update flag
      program_ch(3, 16'h2000, 16'd3);
      rd_stat(st);
      check("R11 flag set by writes", st[4], 1);
      wr(4'd8, 8'h88);
      rd_stat(st);
      check("R11 flag cleared by auto-load mode", st[4], 0);

      // R10 auto-load repeat, R11 cleared by restore
      program_ch(3, 16'h2000, 16'd3);
      rd_stat(st);
      rd_stat(st);
      check("R11 flag survives reads", st[4], 1);
      @(negedge clk); dreq[3] = 1'b1;
      run_blk(ch, first, last, beats);
      check("R10 first run beats", beats, 3);
      rd_stat(st);
      check("R11 flag cleared by restore", st, 8'h08);
      @(negedge clk); dreq[3] = 1'b1;
      run_blk(ch, first, last, beats);
      check("R10 repeat start", first, 16'h2000);
      check("R10 repeat beats", beats, 3);
      check("R10 repeat end", last, 16'h2002);

      // R1/R2 reset returns pointer to low byte mid-pair
      wr(4'd0, 8'hAA);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      program_ch(0, 16'h3456, 16'd1);
      wr(4'd8, 8'h01);
      @(negedge clk); dreq[0] = 1'b1;
      run_blk(ch, first, last, beats);
      check("R2 pointer reset", first, 16'h3456);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule